// File: doc/BRIEF.md
# Serial Write-Only Command and Data Receiver

This block receives bytes over a two-wire serial link (a clock line and a data line) while a strap input selects serial operation. Both lines, and the chip-select and register-select inputs, are brought into the system clock domain through synchronisers. The block oversamples the serial clock, finds its rising edges, and shifts one data bit in on each rising edge, most significant bit first. A 3-bit counter tracks the position of the current bit within the byte.

On the eighth rising edge the assembled byte goes to a holding register. The register-select level at that edge tags the byte as display data (high) or as a command (low). A valid strobe then pulses for exactly one system clock cycle. When chip select goes inactive, or when the strap selects parallel operation, the partial byte and the counter are cleared.

The link only writes. There is no read path, and the block never drives the shared bus.

Top module: `serial_cmd_rx`

## Requirements
- R1: While rst_ni is low and after it is released, word_vld_o is 0, word_o is 0x00 and word_is_data_o is 0 until the first byte completes.
- R2: The first bit sampled after chip select becomes active is bit 7 of word_o, and the eighth bit sampled is bit 0 (most significant bit first).
- R3: Each group of eight serial-clock rising edges, with the block active throughout, produces exactly one word_vld_o pulse, and that pulse is one system clock cycle wide.
- R4: word_is_data_o takes the level of rs_i sampled at the eighth rising edge: 1 marks display data, 0 marks a command.
- R5: If cs_act_i goes low in the middle of a byte, the bits already received are discarded. The next eight rising edges after cs_act_i returns high form a complete new byte.
- R6: While serial_sel_i is 0, serial-clock edges produce no word_vld_o pulse and leave no partial byte behind.
- R7: Changes on rs_i during bits 1 to 7 of a byte have no effect on the tag. Only the level at the eighth edge counts.
- R8: word_o and word_is_data_o change only in the cycle in which word_vld_o is high, and hold their values between pulses.
- R9: word_vld_o is high in the cycle after the third system clock rising edge that follows the eighth serial-clock rise (two synchroniser stages plus one output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| serial_sel_i | input | 1 | Strap, 1 selects serial operation |
| cs_act_i | input | 1 | Chip select, 1 = active |
| rs_i | input | 1 | Register select, 1 = display data, 0 = command |
| sclk_i | input | 1 | Serial clock, asynchronous to clk_i |
| sdata_i | input | 1 | Serial data, sampled on sclk_i rising edge |
| word_o | output | 8 | Last completed byte |
| word_is_data_o | output | 1 | Tag of the last byte (1 = data) |
| word_vld_o | output | 1 | One-cycle strobe per completed byte |

## Verification
The assertions assume that sclk_i stays high and stays low for at least two system clock cycles each, so that no serial edge is lost in the synchronisers. They also assume that sdata_i, rs_i and cs_act_i settle at least two cycles before a serial rising edge. The stimulus holds each serial clock phase for four system cycles. It changes data, register select and chip select only on the falling phase, and it waits before the first edge after chip select or the strap changes. Random bytes and random tags are mixed with directed cases: an aborted byte, the strap held in parallel operation, register select toggled within a byte, and a latency measurement.

// File: rtl/serial_cmd_rx_pkg.sv
package serial_cmd_rx_pkg;
  parameter int unsigned WORD_W      = 8;
  parameter int unsigned SYNC_STAGES = 2;
  localparam int unsigned CNT_W      = $clog2(WORD_W);

  typedef struct packed {
    logic              is_data;
    logic [WORD_W-1:0] bits;
  } rx_word_t;
endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rise_detect.sv
module rise_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_q <= 1'b0;
    else         d_q <= d_i;
  end

  assign rise_o = d_i & ~d_q;
endmodule

// File: rtl/word_assembler.sv
module word_assembler
  import serial_cmd_rx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     active_i,
  input  logic     shift_i,
  input  logic     bit_i,
  input  logic     rs_i,
  output rx_word_t word_o,
  output logic     vld_o
);
  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              last_bit;
  logic [WORD_W-1:0] next_shreg;

  assign next_shreg = {shreg_q[WORD_W-2:0], bit_i};
  assign last_bit   = active_i && shift_i && (cnt_q == CNT_W'(WORD_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (!active_i) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (shift_i) begin
      shreg_q <= next_shreg;
      cnt_q   <= last_bit ? '0 : cnt_q + 1'b1;
    end
  end

  // tag taken together with the final bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= last_bit;
      if (last_bit) begin
        word_o.bits    <= next_shreg;
        word_o.is_data <= rs_i;
      end
    end
  end
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import serial_cmd_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              serial_sel_i,
  input  logic              cs_act_i,
  input  logic              rs_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_is_data_o,
  output logic              word_vld_o
);
  localparam int unsigned NSYNC = 5;

  logic [NSYNC-1:0] raw, synced;
  logic             sclk_rise;
  logic             active;
  rx_word_t         word;

  assign raw = {serial_sel_i, cs_act_i, rs_i, sclk_i, sdata_i};

  sync_bank #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw),
    .q_o    (synced)
  );

  assign active = synced[4] & synced[3];

  rise_detect u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (synced[1]),
    .rise_o (sclk_rise)
  );

  word_assembler u_asm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .shift_i  (sclk_rise),
    .bit_i    (synced[0]),
    .rs_i     (synced[2]),
    .word_o   (word),
    .vld_o    (word_vld_o)
  );

  assign word_o         = word.bits;
  assign word_is_data_o = word.is_data;
endmodule

// File: rtl/serial_cmd_rx_chk.sv
module serial_cmd_rx_chk
  import serial_cmd_rx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              serial_sel_i,
  input logic              cs_act_i,
  input logic [WORD_W-1:0] word_o,
  input logic              word_is_data_o,
  input logic              word_vld_o
);
  p_vld_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o);

  p_word_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_vld_o |-> ($stable(word_o) && $stable(word_is_data_o)));

  p_strap_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!serial_sel_i && !$past(serial_sel_i) && !$past(serial_sel_i, 2) && !$past(serial_sel_i, 3))
      |-> !word_vld_o);

  p_cs_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_act_i && !$past(cs_act_i) && !$past(cs_act_i, 2) && !$past(cs_act_i, 3))
      |-> !word_vld_o);

  always_comb begin
    if (!rst_ni) begin
      p_reset_r1: assert (!word_vld_o && word_o == '0 && !word_is_data_o);
    end
  end
endmodule

bind serial_cmd_rx serial_cmd_rx_chk chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .serial_sel_i   (serial_sel_i),
  .cs_act_i       (cs_act_i),
  .word_o         (word_o),
  .word_is_data_o (word_is_data_o),
  .word_vld_o     (word_vld_o)
);

// File: tb/serial_cmd_rx_tb_top.sv
module serial_cmd_rx_tb_top;
  localparam int HALF = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       serial_sel_i = 1'b1;
  logic       cs_act_i = 1'b0;
  logic       rs_i = 1'b0;
  logic       sclk_i = 1'b0;
  logic       sdata_i = 1'b0;
  logic [7:0] word_o;
  logic       word_is_data_o;
  logic       word_vld_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulses = 0;
  int last_pulse_cyc = 0;
  int last_rise_cyc = 0;
  logic prev_vld = 1'b0;
  logic done = 1'b0;

  serial_cmd_rx dut_i (.*);

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // pulse monitor, sampled away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && word_vld_o) begin
      pulses++;
      last_pulse_cyc = cyc;
      chk(!prev_vld, "R3 width", 2, 1);
    end
    prev_vld = word_vld_o;
  end

  function automatic logic [7:0] exp_word(input logic [7:0] b);
    return b; // bit i sent at position 7-i
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits, input logic rs_final,
                           input bit toggle_rs);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk_i);
      sdata_i = b[7-i];
      rs_i    = (i == 7) ? rs_final : (toggle_rs ? i[0] : rs_final);
      wait_cyc(HALF);
      sclk_i = 1'b1;
      last_rise_cyc = cyc;
      wait_cyc(HALF);
      sclk_i = 1'b0;
    end
    wait_cyc(6);
  endtask

  task automatic send_check(input logic [7:0] b, input logic rs, input bit toggle_rs,
                            input string req);
    int p0 = pulses;
    send_bits(b, 8, rs, toggle_rs);
    chk(pulses == p0 + 1, {req, " R3 count"}, pulses - p0, 1);
    chk(word_o == exp_word(b), {req, " R2 word"}, word_o, exp_word(b));
    chk(word_is_data_o == rs, {req, " R4 tag"}, word_is_data_o, rs);
  endtask

  initial begin
    logic [7:0] hold_w;
    logic       hold_t;
    int p0;
    int seed_dummy;
    seed_dummy = $urandom(32'd2024);
    wait_cyc(3);
    chk(!word_vld_o && word_o == 8'h00 && !word_is_data_o, "R1 in reset", word_o, 0);
    rst_ni = 1'b1;
    wait_cyc(3);
    chk(!word_vld_o && word_o == 8'h00 && !word_is_data_o, "R1 after reset", word_o, 0);
    cs_act_i = 1'b1;
    wait_cyc(5);

    send_check(8'hA5, 1'b0, 1'b0, "R2 directed");
    send_check(8'h80, 1'b1, 1'b0, "R2 msb");
    send_check(8'h01, 1'b0, 1'b0, "R2 lsb");
    send_check(8'hFF, 1'b1, 1'b0, "R4 data");
    chk(last_pulse_cyc - last_rise_cyc == 3, "R9 latency", last_pulse_cyc - last_rise_cyc, 3);

    // R7: rs toggles inside the byte, final level decides
    send_check(8'h3C, 1'b1, 1'b1, "R7 toggle");
    send_check(8'hC3, 1'b0, 1'b1, "R7 toggle");

    // R5: abort after five bits
    hold_w = word_o; hold_t = word_is_data_o;
    p0 = pulses;
    send_bits(8'hF0, 5, 1'b1, 1'b0);
    cs_act_i = 1'b0;
    wait_cyc(8);
    chk(pulses == p0, "R5 no pulse", pulses - p0, 0);
    chk(word_o == hold_w && word_is_data_o == hold_t, "R8 hold", word_o, hold_w);
    cs_act_i = 1'b1;
    wait_cyc(5);
    send_check(8'h5A, 1'b0, 1'b0, "R5 realign");

    // R6: strap in parallel mode
    p0 = pulses;
    serial_sel_i = 1'b0;
    wait_cyc(5);
    send_bits(8'h99, 8, 1'b1, 1'b0);
    send_bits(8'h99, 3, 1'b1, 1'b0);
    chk(pulses == p0, "R6 no pulse", pulses - p0, 0);
    serial_sel_i = 1'b1;
    wait_cyc(5);
    send_check(8'h6E, 1'b1, 1'b0, "R6 clean restart");

    // random bytes
    for (int k = 0; k < 60; k++) begin
      logic [7:0] rb;
      logic       rr;
      rb = 8'($urandom);
      rr = 1'($urandom);
      send_check(rb, rr, 1'($urandom), "R2 random");
    end

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule